// File: doc/BRIEF.md
# Clause 45 Management Interface Master

This block runs the management side of an IEEE 802.3 Clause 45 link to an external PHY. It generates the management clock (MDC) and serialises one frame on the bidirectional data line (MDIO) per command. Each command names an opcode, a PHY port address, a device type and a 16-bit register address. Software starts a frame with a one-cycle `cmdStart` pulse and polls `busy`. A register access takes two frames. An address frame first loads the register address into the PHY. A write or read frame to the same port and device then follows.

A 32-bit data register sits next to the command path. Its low half holds the write data and is loaded through `dataWrEn` before a write frame is started. When a read frame completes, the value shifted in from the PHY lands in the high half, so software shifts the register right by 16 to recover it. The MDC period is the system clock divided by the parameter `MDC_DIV`. Retry policy and the meaning of PHY registers are left to software.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset `busy`, `mdc` and `mdioOe` are 0 and `dataOut` is 0.
- R2: A frame has 32 + 32 bits and is sent most significant bit first. The bits are 32 ones, start bits 00, a 2-bit opcode, a 5-bit port, a 5-bit device, a 2-bit turnaround and 16 data bits. The opcodes are 00 for an address frame, 01 for a write frame and 11 for a read frame. Opcode 10 is also treated as a read.
- R3: An address frame drives turnaround 10 and then the 16-bit register address as its data bits.
- R4: A write frame drives turnaround 10 and then `dataOut[15:0]` as its data bits, using the value held at the cycle the frame was started.
- R5: For a read opcode (opcode bit 1 set), `mdioOe` is high for bits 0 to 45 and low from bit 46 to the end of the frame. For address and write frames it is high for all 64 bits.
- R6: A read frame samples `mdioIn` at the MDC rising edges of bits 48 to 63, first bit as the MSB. It stores the result in `dataOut[31:16]` and leaves `dataOut[15:0]` unchanged.
- R7: MDC has a period of `MDC_DIV` clocks, low for the first half of each bit and high for the second half. It gives exactly 64 rising edges per frame and stays low while idle. MDIO changes only while MDC is low.
- R8: `busy` rises on the clock after an accepted `cmdStart` and stays high for exactly 64*`MDC_DIV` clocks.
- R9: A `cmdStart` pulse that arrives while `busy` is high is ignored. The running frame, its length and its edge count are unchanged, and no second frame follows.
- R10: `dataWrEn` writes `dataWrIn` into `dataOut[15:0]` at any time, including during a frame, without altering the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | One-cycle pulse that starts a frame when idle |
| cmdOp | input | 2 | Opcode: 00 address, 01 write, 11 or 10 read |
| cmdPort | input | 5 | PHY port address |
| cmdDev | input | 5 | Device type within the PHY |
| cmdRegAddr | input | 16 | Register address carried by an address frame |
| dataWrEn | input | 1 | Load strobe for the write-data half |
| dataWrIn | input | 16 | Write data |
| dataOut | output | 32 | Data register: read data high, write data low |
| busy | output | 1 | High while a frame is in progress |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the line |

## Verification
The bench sweeps all 32 port values through address frames. It then runs write and read frames with data patterns that set the MSB and LSB on their own. Each frame is compared bit by bit against an expected word built arithmetically, and the output enable is checked for every bit. The key corner cases are these:
- Off-by-one errors in the turnaround release. A design that gets this wrong drives MDIO against the PHY or floats it one bit early.
- Read capture misaligned by one MDC edge. This shifts the returned value by one bit.
- A restart accepted while busy. This corrupts the frame or produces a second one.
- Write data sampled late rather than at frame start. The bench catches this by changing the data register in the middle of a write frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PortW = 5;
  localparam int DevW  = 5;
  localparam int DataW = 16;
  localparam int OpW   = 2;

  localparam logic [1:0] OP_ADDR  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b11;

  // strobes from the sequencer to the shifter
  typedef struct packed {
    logic load;    // capture a new frame
    logic sample;  // MDC rising edge: take mdioIn
    logic shift;   // MDC falling edge: advance to next bit
    logic finish;  // last bit completed
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_DIV   = 4,
  parameter int FRAME_LEN = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdStart,
  output logic      busy,
  output logic      mdc,
  output mdioStrb_t strb
);
  localparam int HALF  = MDC_DIV / 2;
  localparam int DIV_W = (MDC_DIV > 1) ? $clog2(MDC_DIV) : 1;
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [DIV_W-1:0] DivLast  = DIV_W'(MDC_DIV - 1);
  localparam logic [DIV_W-1:0] HalfLast = DIV_W'(HALF - 1);
  localparam logic [IDX_W-1:0] IdxLast  = IDX_W'(FRAME_LEN - 1);

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic endOfBit;

  assign endOfBit    = busy && (divCnt == DivLast);
  assign strb.load   = cmdStart && !busy;
  assign strb.sample = busy && (divCnt == HalfLast);
  assign strb.shift  = endOfBit;
  assign strb.finish = endOfBit && (bitIdx == IdxLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      if (endOfBit) begin
        divCnt <= '0;
        mdc    <= 1'b0;
        if (bitIdx == IdxLast) busy <= 1'b0;
        else bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
        if (divCnt == HalfLast) mdc <= 1'b1;
      end
    end
  end

  a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  a_r8_finish_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !busy);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> (busy && (bitIdx == $past(bitIdx) ||
                                          bitIdx == $past(bitIdx) + IDX_W'(1))));
  a_r7_rise_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int PRE_BITS  = 32,
  parameter int FRAME_LEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdioStrb_t        strb,
  input  logic             busy,
  input  logic [OpW-1:0]   cmdOp,
  input  logic [PortW-1:0] cmdPort,
  input  logic [DevW-1:0]  cmdDev,
  input  logic [DataW-1:0] cmdRegAddr,
  input  logic             dataWrEn,
  input  logic [DataW-1:0] dataWrIn,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic [2*DataW-1:0] dataOut
);
  // bits driven by the master on a read: everything before turnaround
  localparam int DRIVEN_RD = PRE_BITS + 2 + OpW + PortW + DevW;
  localparam int RELEASED  = FRAME_LEN - DRIVEN_RD;

  logic [FRAME_LEN-1:0] shiftReg;
  logic [FRAME_LEN-1:0] oeMask;
  logic [DataW-1:0]     rdShift;
  logic [2*DataW-1:0]   dataReg;
  logic                 opIsRead;
  logic [DataW-1:0]     payload;
  logic [1:0]           ta;

  assign payload = cmdOp[0] ? dataReg[DataW-1:0] : cmdRegAddr;
  assign ta      = cmdOp[1] ? 2'b11 : 2'b10;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      oeMask   <= '0;
      opIsRead <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= {{PRE_BITS{1'b1}}, 2'b00, cmdOp, cmdPort, cmdDev, ta, payload};
      oeMask   <= cmdOp[1] ? {{DRIVEN_RD{1'b1}}, {RELEASED{1'b0}}} : '1;
      opIsRead <= cmdOp[1];
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b1};
      oeMask   <= {oeMask[FRAME_LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdShift <= '0;
    else if (strb.sample) rdShift <= {rdShift[DataW-2:0], mdioIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else begin
      if (dataWrEn) dataReg[DataW-1:0] <= dataWrIn;
      if (strb.finish && opIsRead) dataReg[2*DataW-1:DataW] <= rdShift;
    end
  end

  assign mdioOut = shiftReg[FRAME_LEN-1];
  assign mdioOe  = busy && oeMask[FRAME_LEN-1];
  assign dataOut = dataReg;

  a_r6_high_half_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(dataReg[2*DataW-1:DataW]));
  a_r10_low_half_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrEn |=> $stable(dataReg[DataW-1:0]));
  a_r7_mdio_still_when_high: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.shift && !strb.load) |=> $stable(shiftReg[FRAME_LEN-1]));
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_pkg::*;
#(
  parameter int MDC_DIV  = 4,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic [1:0]  cmdOp,
  input  logic [4:0]  cmdPort,
  input  logic [4:0]  cmdDev,
  input  logic [15:0] cmdRegAddr,
  input  logic        dataWrEn,
  input  logic [15:0] dataWrIn,
  output logic [31:0] dataOut,
  output logic        busy,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int FRAME_LEN = PRE_BITS + 2 + OpW + PortW + DevW + 2 + DataW;

  mdioStrb_t strb;

  mdio_ctrl #(.MDC_DIV(MDC_DIV), .FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart),
    .busy(busy), .mdc(mdc), .strb(strb)
  );

  mdio_dp #(.PRE_BITS(PRE_BITS), .FRAME_LEN(FRAME_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .cmdOp(cmdOp), .cmdPort(cmdPort), .cmdDev(cmdDev), .cmdRegAddr(cmdRegAddr),
    .dataWrEn(dataWrEn), .dataWrIn(dataWrIn), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .dataOut(dataOut)
  );

  a_r5_oe_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
  a_r8_busy_rises_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !busy) |=> busy);
endmodule

// File: tb/mdio_c45_master_tb.sv
module mdio_c45_master_tb;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [4:0] cmdPort = '0;
  logic [4:0] cmdDev = '0;
  logic [15:0] cmdRegAddr = '0;
  logic dataWrEn = 1'b0;
  logic [15:0] dataWrIn = '0;
  logic [31:0] dataOut;
  logic busy, mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  int edgeCount = 0;
  logic [63:0] capOut = '0;
  logic [63:0] capOe = '0;
  logic [15:0] phyData = '0;

  always #2 clk = ~clk;

  mdio_c45_master #(.MDC_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdOp(cmdOp),
    .cmdPort(cmdPort), .cmdDev(cmdDev), .cmdRegAddr(cmdRegAddr),
    .dataWrEn(dataWrEn), .dataWrIn(dataWrIn), .dataOut(dataOut),
    .busy(busy), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // line monitor: what the PHY sees at each MDC rising edge
  always @(posedge mdc) begin
    capOut = {capOut[62:0], mdioOut};
    capOe  = {capOe[62:0], mdioOe};
    edgeCount = edgeCount + 1;
  end

  // PHY model: presents the next bit after each falling edge
  always @(negedge mdc) begin
    if (edgeCount >= 48 && edgeCount < 64) mdioIn = phyData[63 - edgeCount];
    else mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic writeData(input logic [15:0] v);
    @(negedge clk);
    dataWrIn = v;
    dataWrEn = 1'b1;
    @(negedge clk);
    dataWrEn = 1'b0;
    check(dataOut[15:0] == v, "R10 write-data load", {48'd0, dataOut[15:0]}, {48'd0, v});
  endtask

  // runs one frame; midWr changes write data mid-frame, junk issues an ignored command
  task automatic runFrame(input logic [1:0] op, input logic [4:0] port,
                          input logic [4:0] dev, input logic [15:0] addr,
                          input logic [15:0] rd, input bit midWr, input bit junk);
    logic [15:0] wrSnap;
    logic [15:0] payload;
    logic [63:0] expFrame;
    logic [63:0] expOe;
    logic [31:0] expData;
    int busyLen;
    @(negedge clk);
    edgeCount = 0;
    phyData = rd;
    wrSnap = dataOut[15:0];
    cmdOp = op; cmdPort = port; cmdDev = dev; cmdRegAddr = addr;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    check(busy == 1'b1, "R8 busy after start", {63'd0, busy}, 64'd1);
    busyLen = 0;
    while (busy && busyLen < 1000) begin
      busyLen++;
      if (junk && busyLen == 10) begin
        cmdOp = ~op; cmdPort = ~port; cmdDev = ~dev; cmdRegAddr = ~addr;
        cmdStart = 1'b1;
      end else cmdStart = 1'b0;
      if (midWr && busyLen == 20) begin dataWrIn = ~wrSnap; dataWrEn = 1'b1; end
      else dataWrEn = 1'b0;
      @(negedge clk);
    end
    cmdStart = 1'b0;
    dataWrEn = 1'b0;
    check(busyLen == 64 * DIV, "R8 busy length", 64'(busyLen), 64'(64 * DIV));
    check(edgeCount == 64, "R7 MDC rising edges", 64'(edgeCount), 64'd64);
    check(mdc == 1'b0, "R7 MDC idle low", {63'd0, mdc}, 64'd0);
    payload = (op == 2'b00) ? addr : wrSnap;
    expFrame = {32'hFFFF_FFFF, 2'b00, op, port, dev, 2'b10, payload};
    expOe = op[1] ? {{46{1'b1}}, 18'd0} : '1;
    check(capOe == expOe, "R5 output enable per bit", capOe, expOe);
    if (op[1]) begin
      check(capOut[63:18] == expFrame[63:18], "R2 read header", capOut, expFrame);
      expData = {rd, midWr ? ~wrSnap : wrSnap};
      check(dataOut == expData, "R6 read data placement", {32'd0, dataOut}, {32'd0, expData});
    end else begin
      check(capOut == expFrame, op[0] ? "R4 write frame" : "R3 address frame",
            capOut, expFrame);
      if (midWr)
        check(dataOut[15:0] == ~wrSnap, "R10 mid-frame write lands",
              {48'd0, dataOut[15:0]}, {48'd0, ~wrSnap});
    end
    if (junk) begin
      repeat (3 * DIV) @(negedge clk);
      check(busy == 1'b0 && edgeCount == 64, "R9 no second frame",
            64'(edgeCount), 64'd64);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", {63'd0, busy}, 64'd0);
    check(mdc == 1'b0, "R1 mdc", {63'd0, mdc}, 64'd0);
    check(mdioOe == 1'b0, "R1 oe", {63'd0, mdioOe}, 64'd0);
    check(dataOut == 32'd0, "R1 data", {32'd0, dataOut}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3: address frames over every port
    for (int p = 0; p < 32; p++)
      runFrame(2'b00, 5'(p), 5'((p * 7) % 32), 16'(p * 16'h0811) ^ 16'hA5C3,
               16'h0, 1'b0, 1'b0);

    // R4: write frames
    for (int w = 0; w < 6; w++) begin
      logic [15:0] pat;
      pat = (w == 0) ? 16'h0000 : (w == 1) ? 16'hFFFF : (w == 2) ? 16'h8000 :
            (w == 3) ? 16'h0001 : 16'(16'h1357 * (w + 1));
      writeData(pat);
      runFrame(2'b01, 5'(w + 3), 5'(30 - w), 16'h0, 16'h0, 1'b0, 1'b0);
    end
    // R10: write data changed during a write frame
    writeData(16'h6C39);
    runFrame(2'b01, 5'd1, 5'd1, 16'h0, 16'h0, 1'b1, 1'b0);

    // R5/R6: read frames with both read opcodes
    for (int r = 0; r < 8; r++) begin
      logic [15:0] rv;
      rv = (r == 0) ? 16'h0000 : (r == 1) ? 16'hFFFF : (r == 2) ? 16'h8001 :
           (r == 3) ? 16'h7FFE : 16'(16'hB4E1 ^ (r * 16'h2A93));
      runFrame((r % 2 == 0) ? 2'b11 : 2'b10, 5'(r), 5'(r + 9), 16'h0, rv,
               1'b0, 1'b0);
    end
    // R6 with the write half written during the read
    runFrame(2'b11, 5'd2, 5'd4, 16'h0, 16'hC3A5, 1'b1, 1'b0);

    // R9: restart attempts while busy, on each frame kind
    runFrame(2'b00, 5'd5, 5'd6, 16'h4D2B, 16'h0, 1'b0, 1'b1);
    runFrame(2'b11, 5'd7, 5'd1, 16'h0, 16'h5AA5, 1'b0, 1'b1);
    summary();
  end
endmodule